// File: doc/BRIEF.md
# Chip-Selected SMBus Configuration Register Target

This block is a byte-oriented SMBus target. A host uses it to read and write a small bank of configuration registers, and to read one byte of live status. It runs entirely from the system clock. SCL, SDA and the chip select are each brought into that clock domain through a flop chain, and the block finds bus edges, START and STOP on the synchronized copies. SDA is open drain: the block never drives it high. It only asserts an output enable that pulls the line low.

The port answers only while the chip select is high. While it is low, the block ignores every bus edge, keeps its state unchanged and never pulls SDA. This lets other targets share the bus. A write sets the register pointer and then stores one data byte. A read sets the pointer with a write, then uses a repeated START with the read bit to fetch one byte. The pointer stays set between transactions and does not advance by itself. If SCL stays low for longer than a programmable number of clocks in the middle of a transfer, the target drops back to idle.

The read/write registers are sent out in parallel to the control logic, which uses them as its settings. The status byte comes in from that logic. The port keeps working no matter what mode that logic is in.

Top module: `smb_cfg_target`

## Requirements
- R1: After reset the register outputs hold 0x77 at pointers 0x03 and 0x04, 0x00 at 0x05, 0x06 and 0x07, and 0x78 at 0x08. `cfg_o[8*k+7:8*k]` carries pointer 0x03+k. SDA is not driven.
- R2: A write transaction is START, byte 0xAC (target address 1010110 followed by write bit 0), pointer byte, data byte, STOP. The target pulls SDA low in the ninth clock of each of these three bytes, and the data byte appears on the register output of that pointer.
- R3: A read is START, 0xAC, pointer, repeated START, 0xAD, then one byte that the target shifts out MSB first during the eight SCL high phases, then a host NACK, then STOP. The target acknowledges all three header bytes.
- R4: Pointer 0x00 returns `status_i`, captured at the start of the data byte. A status change while the byte is being shifted out does not alter that byte. Pointers 0x01 and 0x02 return 0x00.
- R5: An address byte other than 0xAC/0xAD is not acknowledged. The target then drives nothing until the next START, and bytes sent after it change no register.
- R6: A write to a pointer outside 0x03 to 0x08 is acknowledged but changes no register. Reading a pointer outside 0x00 to 0x08 returns 0x00.
- R7: While `cs_i` is low, the target never drives SDA and a complete write transaction changes nothing. Once `cs_i` is high again, the same transaction works normally.
- R8: If SCL stays low for `TMO_CYC` clocks while a transfer is open, the target returns to idle. Bits clocked after that, without a new START, are neither acknowledged nor stored.
- R9: The pointer persists. A read that starts directly with 0xAD returns the register last addressed.
- R10: Only one data byte per write is accepted. A further byte in the same transaction is not acknowledged and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, high enables the port |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe_o | output | 1 | Pull SDA low when high |
| status_i | input | 8 | Live status byte returned at pointer 0x00 |
| cfg_o | output | 8*NUM_RW | Read/write registers, byte k is pointer FIRST_RW+k |

## Verification
Two things can happen in the same stretch of clocks. The live status input can change while the data byte is being loaded and shifted out of a read. A read can also follow immediately on the write of the same register. The bench flips `status_i` halfway through a read of pointer 0x00. Its scoreboard expects the value present when the byte started, and the next read must return the new value. The bench also reads back registers right after writing them, and checks that the scoreboard holds the freshly written byte rather than the reset value.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ACK_A, S_REG, S_ACK_R,
    S_DATA, S_ACK_D, S_TX, S_HACK, S_WAIT
  } eng_st_e;

  localparam logic [7:0] STATUS_PTR = 8'h00;

  // power-on value of a read/write register, by pointer
  function automatic logic [7:0] reg_reset(input int ptr);
    case (ptr)
      3, 4:    return 8'h77;
      8:       return 8'h78;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic is_rw(input logic [7:0] ptr, input int first, input int num);
    return (int'(ptr) >= first) && (int'(ptr) < first + num);
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic cs_s,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  localparam logic [2:0] IDLE_LVL = 3'b011; // cs low, scl and sda released

  logic [2:0] stg [STAGES];
  logic       scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= IDLE_LVL;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      stg[0] <= {cs_i, scl_i, sda_i};
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
      scl_q <= stg[STAGES-1][1];
      sda_q <= stg[STAGES-1][0];
    end
  end

  assign {cs_s, scl_s, sda_s} = stg[STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
  import smb_cfg_pkg::*;
#(
  parameter int FIRST_RW = 3,
  parameter int NUM_RW   = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [7:0]            ptr,
  input  logic [7:0]            wr_data,
  input  logic [7:0]            status_i,
  output logic [7:0]            rd_data,
  output logic [8*NUM_RW-1:0]   cfg_o
);

  for (genvar g = 0; g < NUM_RW; g++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               q <= reg_reset(FIRST_RW + g);
      else if (wr_en && ptr == 8'(FIRST_RW + g)) q <= wr_data;
    end
    assign cfg_o[8*g +: 8] = q;
  end

  always_comb begin
    rd_data = 8'h00;
    if (ptr == STATUS_PTR) rd_data = status_i;
    for (int k = 0; k < NUM_RW; k++)
      if (ptr == 8'(FIRST_RW + k)) rd_data = cfg_o[8*k +: 8];
  end

  AST_RO_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !is_rw(ptr, FIRST_RW, NUM_RW)) |=> $stable(cfg_o)); // R6

endmodule

// File: rtl/smb_bit_engine.sv
module smb_bit_engine
  import smb_cfg_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'b1010110,
  parameter int         TMO_CYC     = 3_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_s,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic [7:0] rd_data,
  output logic       sda_drv,
  output logic       wr_en,
  output logic [7:0] ptr,
  output logic [7:0] wr_data
);
  localparam int TMO_W = $clog2(TMO_CYC + 1);

  eng_st_e          st;
  logic [7:0]       sh;
  logic [6:0]       tx;
  logic [3:0]       cnt;
  logic             rw;
  logic [TMO_W-1:0] tmo_cnt;
  logic             en, byte_done, tmo_hit;

  assign en        = cs_s;
  assign byte_done = en && scl_fall && cnt == 4'd8;
  assign tmo_hit   = en && !scl_s && st != S_IDLE && tmo_cnt == TMO_W'(TMO_CYC - 1);
  assign wr_en     = byte_done && st == S_DATA;
  assign wr_data   = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    tmo_cnt <= '0;
    else if (en) begin
      if (scl_s || st == S_IDLE)  tmo_cnt <= '0;
      else if (!tmo_hit)          tmo_cnt <= tmo_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sh <= '0; tx <= '0; cnt <= '0; rw <= 1'b0; ptr <= '0; sda_drv <= 1'b0;
    end else if (en) begin
      if (start_ev) begin
        st <= S_ADDR; cnt <= '0; sda_drv <= 1'b0;
      end else if (stop_ev || tmo_hit) begin
        st <= S_IDLE; sda_drv <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_REG, S_DATA: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (byte_done) begin
              cnt <= '0;
              if (st == S_ADDR) begin
                if (sh[7:1] == TARGET_ADDR) begin
                  rw <= sh[0]; sda_drv <= 1'b1; st <= S_ACK_A;
                end else st <= S_WAIT;
              end else if (st == S_REG) begin
                ptr <= sh; sda_drv <= 1'b1; st <= S_ACK_R;
              end else begin
                sda_drv <= 1'b1; st <= S_ACK_D;
              end
            end
          end
          S_ACK_A: if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              tx <= rd_data[6:0]; sda_drv <= ~rd_data[7]; st <= S_TX;
            end else begin
              sda_drv <= 1'b0; st <= S_REG;
            end
          end
          S_ACK_R: if (scl_fall) begin sda_drv <= 1'b0; st <= S_DATA; end
          S_ACK_D: if (scl_fall) begin sda_drv <= 1'b0; st <= S_WAIT; end
          S_TX: if (scl_fall) begin
            if (cnt == 4'd7) begin
              sda_drv <= 1'b0; st <= S_HACK;
            end else begin
              cnt <= cnt + 1'b1; sda_drv <= ~tx[6]; tx <= {tx[5:0], 1'b0};
            end
          end
          S_HACK: if (scl_fall) st <= S_WAIT;
          default: ;
        endcase
      end
    end
  end

  AST_FROZEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> $stable(st)); // R7
  AST_FOREIGN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |-> !sda_drv); // R5
  AST_WRITE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sda_drv); // R2
  AST_TMO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> (st == S_IDLE)); // R8
  AST_TX_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TX) |-> rw); // R3
  AST_PTR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TX) |=> $stable(ptr)); // R9

endmodule

// File: rtl/smb_cfg_target.sv
module smb_cfg_target #(
  parameter logic [6:0] TARGET_ADDR = 7'b1010110,
  parameter int         SYNC_STAGES = 2,
  parameter int         FIRST_RW    = 3,
  parameter int         NUM_RW      = 6,
  parameter int         TMO_CYC     = 3_000_000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_i,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe_o,
  input  logic [7:0]          status_i,
  output logic [8*NUM_RW-1:0] cfg_o
);
  logic       cs_s, scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic       sda_drv, wr_en;
  logic [7:0] ptr, wr_data, rd_data;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .scl_i(scl_i), .sda_i(sda_i),
    .cs_s(cs_s), .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev));

  smb_bit_engine #(.TARGET_ADDR(TARGET_ADDR), .TMO_CYC(TMO_CYC)) u_eng (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev),
    .stop_ev(stop_ev), .rd_data(rd_data), .sda_drv(sda_drv), .wr_en(wr_en),
    .ptr(ptr), .wr_data(wr_data));

  smb_reg_bank #(.FIRST_RW(FIRST_RW), .NUM_RW(NUM_RW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ptr(ptr), .wr_data(wr_data),
    .status_i(status_i), .rd_data(rd_data), .cfg_o(cfg_o));

  assign sda_oe_o = sda_drv & cs_s;

  AST_NO_DRIVE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_i && $past(!cs_i) && $past(!cs_i, 2)) |-> !sda_oe_o); // R7

endmodule

// File: tb/smb_cfg_target_test.sv
module smb_cfg_target_test;
  localparam int CLK_PER = 10;
  localparam int TMO     = 400;
  localparam int Q       = 8;
  localparam int NUM_RW  = 6;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b1, scl = 1'b1, host_sda = 1'b1;
  logic [7:0] status = 8'h00;
  logic sda_oe, sda_bus;
  logic [8*NUM_RW-1:0] cfg;

  assign sda_bus = host_sda & ~sda_oe;
  always #(CLK_PER/2) clk = ~clk;

  smb_cfg_target #(.TMO_CYC(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .status_i(status), .cfg_o(cfg));

  int total = 0, bad = 0, drv_cnt = 0;
  logic [7:0] mdl [3:8];
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got;
  event       rd_done;
  logic       swap_en = 1'b0;
  logic [7:0] swap_val = 8'h00;

  always @(posedge clk) if (sda_oe) drv_cnt++;

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [8*NUM_RW-1:0] packm();
    logic [8*NUM_RW-1:0] r;
    for (int k = 0; k < NUM_RW; k++) r[8*k +: 8] = mdl[3+k];
    return r;
  endfunction

  // scoreboard monitor
  initial forever begin
    @(rd_done);
    if (exp_q.size() == 0) begin
      total++; bad++;
      $display("FAIL R3 unexpected read actual=%0h expected=none", got);
    end else chk(got, exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic wq; repeat (Q) @(posedge clk); #1; endtask
  task automatic bus_start; host_sda = 1'b1; wq; scl = 1'b1; wq; host_sda = 1'b0; wq; scl = 1'b0; wq; endtask
  task automatic bus_stop; host_sda = 1'b0; wq; scl = 1'b1; wq; host_sda = 1'b1; wq; endtask
  task automatic put_bit(input logic b); host_sda = b; wq; scl = 1'b1; wq; wq; scl = 1'b0; wq; endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    host_sda = 1'b1; wq; scl = 1'b1; wq; ack = (sda_bus === 1'b0); wq; scl = 1'b0; wq;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      host_sda = 1'b1; wq; scl = 1'b1; wq; v[i] = sda_bus;
      if (swap_en && i == 4) status = swap_val;
      wq; scl = 1'b0; wq;
    end
    put_bit(nack);
  endtask

  task automatic wr_txn(input logic [7:0] a8, input logic [7:0] p, input logic [7:0] d,
                        output logic [2:0] acks);
    logic a1, a2, a3;
    bus_start; send_byte(a8, a1); send_byte(p, a2); send_byte(d, a3); bus_stop;
    acks = {a1, a2, a3};
  endtask

  task automatic push_read(input logic [7:0] v, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag); got = v; ->rd_done;
    @(posedge clk); #1;
  endtask

  task automatic rd_expect(input logic [7:0] p, input logic [7:0] exp, input string tag);
    logic a1, a2, a3; logic [7:0] v;
    bus_start; send_byte(8'hAC, a1); send_byte(p, a2);
    bus_start; send_byte(8'hAD, a3); recv_byte(1'b1, v); bus_stop;
    chk({a1, a2, a3}, 3'b111, {tag, " header acks"});
    push_read(v, exp, tag);
  endtask

  initial begin
    logic [2:0] acks; logic a; logic [7:0] v;
    mdl[3] = 8'h77; mdl[4] = 8'h77; mdl[5] = 8'h00;
    mdl[6] = 8'h00; mdl[7] = 8'h00; mdl[8] = 8'h78;
    repeat (5) @(posedge clk); #1 rst_n = 1'b1; repeat (5) @(posedge clk); #1;

    chk(cfg, packm(), "R1 reset register values");
    chk(sda_oe, 1'b0, "R1 SDA released after reset");

    wr_txn(8'hAC, 8'h05, 8'hA5, acks); mdl[5] = 8'hA5;
    chk(acks, 3'b111, "R2 write acks");
    chk(cfg, packm(), "R2 write lands");
    rd_expect(8'h05, 8'hA5, "R3 read back 0x05");
    rd_expect(8'h08, 8'h78, "R3 read default 0x08");

    status = 8'h3C;
    rd_expect(8'h00, 8'h3C, "R4 status read");
    rd_expect(8'h01, 8'h00, "R4 zero status 0x01");
    swap_en = 1'b1; swap_val = 8'hC3;
    rd_expect(8'h00, 8'h3C, "R4 snapshot during shift");
    swap_en = 1'b0;
    rd_expect(8'h00, 8'hC3, "R4 live after change");

    drv_cnt = 0;
    wr_txn(8'hA8, 8'h03, 8'h11, acks);
    chk(acks, 3'b000, "R5 foreign address not acked");
    chk(drv_cnt, 0, "R5 no drive after foreign address");
    chk(cfg, packm(), "R5 no register change");

    wr_txn(8'hAC, 8'h01, 8'hFF, acks);
    chk(acks, 3'b111, "R6 RO write acked");
    wr_txn(8'hAC, 8'h40, 8'hFF, acks);
    chk(acks, 3'b111, "R6 unimplemented write acked");
    chk(cfg, packm(), "R6 registers unchanged");
    rd_expect(8'h40, 8'h00, "R6 unimplemented reads zero");
    rd_expect(8'h02, 8'h00, "R6 RO stays zero");

    cs = 1'b0; repeat (10) @(posedge clk); #1; drv_cnt = 0;
    wr_txn(8'hAC, 8'h03, 8'h12, acks);
    chk(acks, 3'b000, "R7 deselected no acks");
    chk(drv_cnt, 0, "R7 deselected never drives");
    chk(cfg, packm(), "R7 deselected no change");
    cs = 1'b1; repeat (10) @(posedge clk); #1;
    wr_txn(8'hAC, 8'h03, 8'h12, acks); mdl[3] = 8'h12;
    chk(acks, 3'b111, "R7 reselected acks");
    chk(cfg, packm(), "R7 reselected write");

    bus_start; send_byte(8'hAC, a);
    chk(a, 1'b1, "R8 address acked before stall");
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    repeat (TMO + 50) @(posedge clk); #1;
    send_byte(8'h05, a); chk(a, 1'b0, "R8 no ack after timeout");
    send_byte(8'hEE, a); chk(a, 1'b0, "R8 no ack on data after timeout");
    bus_stop;
    chk(cfg, packm(), "R8 nothing stored after timeout");

    wr_txn(8'hAC, 8'h04, 8'h5A, acks); mdl[4] = 8'h5A;
    chk(acks, 3'b111, "R9 write acks");
    bus_start; send_byte(8'hAD, a); recv_byte(1'b1, v); bus_stop;
    chk(a, 1'b1, "R9 direct read acked");
    push_read(v, 8'h5A, "R9 pointer retained");

    bus_start; send_byte(8'hAC, acks[2]); send_byte(8'h06, acks[1]); send_byte(8'h33, acks[0]);
    send_byte(8'h44, a); bus_stop; mdl[6] = 8'h33;
    chk(acks, 3'b111, "R10 first data byte acked");
    chk(a, 1'b0, "R10 second data byte refused");
    chk(cfg, packm(), "R10 only first byte stored");

    repeat (4) @(posedge clk);
    chk(exp_q.size(), 0, "R3 scoreboard drained");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule